// File: doc/BRIEF.md
# Write Buffer Status Timer

This block produces the status word of a bus write buffer whose busy flags come from timing alone. No data is tracked. Each bus write is seen as a one-cycle strobe. The write stamps on and off deadlines for three flags, measured against a free-running cycle counter that the block receives as an input. The status word is composed at once from those deadlines, the current counter value and a small amount of stored state.

Three flags carry the timing. Bit 5 is a short "write just happened" flag. Bit 4 is a delayed busy flag whose hold time grows with each back-to-back write. Bit 0 is a longer, later busy flag that also stretches under back-to-back writes. Bits 3 to 1 are wired to read as one. A reader may sample the status output on any cycle.

Top module: `wbuf_status_timer`

## Requirements
- R1: A write at counter value W makes status bit 5 read 1 from the next cycle until the counter reaches W+8, where it reads 0. A later write restarts this window from its own counter value.
- R2: If bit 4's off deadline is strictly earlier than the write's counter value W, the write moves bit 4's on deadline to W+8.
- R3: Every write sets bit 4's off deadline to the later of W and the existing off deadline, plus 16. Back-to-back writes therefore push the off deadline forward by at least 16 each time.
- R4: If bit 0's off deadline is strictly earlier than W, the write sets bit 0's on deadline to W+24 and its off deadline to W+48.
- R5: If bit 0's off deadline is not earlier than W, the write leaves bit 0's on deadline unchanged and adds 24 to its off deadline.
- R6: A flag reads 0 once the counter has reached its off deadline. Otherwise it reads 1 once the counter has reached its on deadline. Otherwise it keeps its held value. Bit 5's held value returns to 0 once its off deadline has passed.
- R7: Status bits 3, 2 and 1 always read 1. Every bit above 5 reads 0.
- R8: Deadline comparisons use the signed difference of the counter and the deadline, so behaviour is unchanged when the counter wraps past its maximum value.
- R9: During reset every deadline follows the counter and every held flag is 0, so the status reads 0x0E after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_cnt | input | CW | Free-running cycle counter value ("now") |
| wr_en | input | 1 | One bus write per cycle in which it is high |
| status | output | SW | Composed status word |

## Verification
The assertions check on every cycle that bit 5 is up on the cycle after a write, that bit 4's off deadline moves by at least 16 on each write, that a busy bit 0 gains exactly 24 cycles, that deadlines hold still without a write, and that a stale bit 5 is dropped. The bench scenarios are needed for the exact cycles at which each flag rises and falls. They cover a single isolated write, two writes on consecutive cycles with their stretched windows, and a write placed so that its windows straddle the counter wrap.

// File: rtl/wbuf_status_timer.sv
module wbuf_status_timer #(
  parameter int CW       = 32,
  parameter int SW       = 32,
  parameter int B5_HOLD  = 8,
  parameter int B4_DELAY = 8,
  parameter int B4_HOLD  = 16,
  parameter int B0_DELAY = 24,
  parameter int B0_HOLD  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cycle_cnt,
  input  logic          wr_en,
  output logic [SW-1:0] status
);

  localparam logic [CW-1:0] K5H = CW'(B5_HOLD);
  localparam logic [CW-1:0] K4D = CW'(B4_DELAY);
  localparam logic [CW-1:0] K4H = CW'(B4_HOLD);
  localparam logic [CW-1:0] K0D = CW'(B0_DELAY);
  localparam logic [CW-1:0] K0H = CW'(B0_HOLD);

  logic [CW-1:0] b5_off, b4_on, b4_off, b0_on, b0_off;
  logic          h5, h4, h0;

  logic [CW-1:0] d5_off, d4_on, d4_off, d0_on, d0_off;
  assign d5_off = cycle_cnt - b5_off;
  assign d4_on  = cycle_cnt - b4_on;
  assign d4_off = cycle_cnt - b4_off;
  assign d0_on  = cycle_cnt - b0_on;
  assign d0_off = cycle_cnt - b0_off;

  // reached: signed (now - deadline) >= 0 ; passed: strictly > 0
  logic r5_off, r4_on, r4_off, r0_on, r0_off, p4_off, p0_off;
  assign r5_off = ~d5_off[CW-1];
  assign r4_on  = ~d4_on[CW-1];
  assign r4_off = ~d4_off[CW-1];
  assign r0_on  = ~d0_on[CW-1];
  assign r0_off = ~d0_off[CW-1];
  assign p4_off = r4_off && (d4_off != '0);
  assign p0_off = r0_off && (d0_off != '0);

  logic f5, f4, f0;
  assign f5 = r5_off ? 1'b0 : h5;
  assign f4 = r4_off ? 1'b0 : (r4_on ? 1'b1 : h4);
  assign f0 = r0_off ? 1'b0 : (r0_on ? 1'b1 : h0);

  always_comb begin
    status    = '0;
    status[5] = f5;
    status[4] = f4;
    status[3] = 1'b1;
    status[2] = 1'b1;
    status[1] = 1'b1;
    status[0] = f0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b5_off <= cycle_cnt;
      b4_on  <= cycle_cnt;
      b4_off <= cycle_cnt;
      b0_on  <= cycle_cnt;
      b0_off <= cycle_cnt;
      h5 <= 1'b0;
      h4 <= 1'b0;
      h0 <= 1'b0;
    end else begin
      h5 <= wr_en ? 1'b1 : f5;
      h4 <= f4;
      h0 <= f0;
      if (wr_en) begin
        b5_off <= cycle_cnt + K5H;
        if (p4_off) b4_on <= cycle_cnt + K4D;
        b4_off <= (r4_off ? cycle_cnt : b4_off) + K4H;
        if (p0_off) begin
          b0_on  <= cycle_cnt + K0D;
          b0_off <= cycle_cnt + K0D + K0H;
        end else begin
          b0_off <= b0_off + K0H;
        end
      end
    end
  end

  AST_B5_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status[5]); // R1

  AST_B4_OFF_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !((b4_off - $past(b4_off) - K4H) >> (CW-1))); // R3

  AST_B0_BUSY_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !p0_off) |=> (b0_off - $past(b0_off) == K0H) && $stable(b0_on)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(b4_off) && $stable(b0_off) && $stable(b5_off)); // R3

  AST_B5_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && r5_off) |=> !h5); // R6

endmodule

// File: tb/wbuf_status_timer_test.sv
module wbuf_status_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt = 32'd0;
  logic        wr = 1'b0;
  logic [31:0] status;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  wbuf_status_timer uut (
    .clk(clk), .rst_n(rst_n), .cycle_cnt(cnt), .wr_en(wr), .status(status)
  );

  // {offset from write counter, expected status}: single isolated write
  localparam logic [39:0] SINGLE [9] = '{
    {32'd1,  8'h2E}, {32'd7,  8'h2E}, {32'd8,  8'h1E}, {32'd15, 8'h1E},
    {32'd16, 8'h0E}, {32'd23, 8'h0E}, {32'd24, 8'h0F}, {32'd47, 8'h0F},
    {32'd48, 8'h0E}
  };

  task automatic tick(input logic w);
    wr = w;
    @(posedge clk);
    #1;
    cnt = cnt + 1;
    wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    #5;
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s: cnt=%0h status=%0h expected=%0h", req, cnt, status, exp);
    end
  endtask

  task automatic walk_single(input string req);
    logic [31:0] w0;
    w0 = cnt;
    tick(1'b1);
    for (int i = 0; i < 9; i++) begin
      while (cnt - w0 < SINGLE[i][39:8]) tick(1'b0);
      check(req, {24'd0, SINGLE[i][7:0]});
    end
  endtask

  task automatic wait_to(input logic [31:0] base, input logic [31:0] d);
    while (cnt - base < d) tick(1'b0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w0;
    cnt = 32'd100;
    tick(1'b0); tick(1'b0); tick(1'b0);
    rst_n = 1'b1;
    check("R9 reset", 32'h0E);
    tick(1'b0);
    check("R7 idle", 32'h0E);

    // R1 R2 R4 R6 R7: single write
    walk_single("R1/R2/R4/R6 single");

    // R3 R5: two writes on consecutive cycles
    tick(1'b0); tick(1'b0);
    w0 = cnt;
    tick(1'b1);
    tick(1'b1);
    wait_to(w0, 8);  check("R1 restart b5", 32'h3E);
    wait_to(w0, 9);  check("R1 b5 off", 32'h1E);
    wait_to(w0, 24); check("R3 b4 extended", 32'h1F);
    wait_to(w0, 31); check("R3 b4 end-1", 32'h1F);
    wait_to(w0, 32); check("R3 b4 off", 32'h0F);
    wait_to(w0, 71); check("R5 b0 extended", 32'h0F);
    wait_to(w0, 72); check("R5 b0 off", 32'h0E);

    // R8: windows straddle counter wrap
    rst_n = 1'b0;
    cnt = 32'hFFFF_FFF0;
    tick(1'b0); tick(1'b0);
    rst_n = 1'b1;
    check("R9 reset near wrap", 32'h0E);
    wait_to(32'hFFFF_FFF0, 8);
    walk_single("R8 wrap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule